// File: doc/BRIEF.md
# Three-Approach Intersection Signal Controller

This block drives the green lights of a junction with three approaches: north, south and east. Each approach has a car-present sensor bit and a go output. A sensor pulse is remembered in a sticky request bit, so a car that is seen for only one cycle is still served later.

North and south may be green together. While either of them is green, a shared hold flag keeps east red. A pending east request stops any new north or south green. East turns green only when the hold flag is clear.

A green light goes off as soon as its sensor reads low, and that clears the request for its approach. The hold flag must be released correctly in two cases. In the first, one of the north/south pair turns off in the same cycle that the other turns on. In the second, both turn off in the same cycle. All state is registered on the rising clock edge, and the reset is synchronous and active high.

Top module: `tlc_intersection`

## Requirements
- R1: While reset is high at a clock edge, all three go outputs, every request bit and the hold flag are 0 after that edge.
- R2: A sensor that is high at a clock edge sets its approach's request bit at that edge. The bit stays set after the sensor falls, until that approach's light turns off. A single-cycle sensor pulse on a red approach therefore produces a green two edges after the pulse.
- R3: North (and likewise south) turns green at an edge when its request is set, its light is off and no east request is set. The turn-on also sets the hold flag.
- R4: A green light whose sensor is low at an edge turns off at that edge and clears its request. With the sensor still low, the light stays off afterwards.
- R5: While an east request is pending, neither north nor south turns green. Once east is served and its request is cleared, a waiting north or south request turns green on the next edge.
- R6: East turns green only when its request is set, its light is off and the hold flag is clear. A north or south light that is already green keeps east red until that light turns off.
- R7: The east go output is never high in the same cycle as the north or south go output.
- R8: If south turns off in the same edge that north turns on, the hold flag stays set and east stays red while north is green. The symmetric case, north off while south turns on, behaves the same way.
- R9: If north and south turn off in the same edge, the hold flag is released, and a pending east request turns green on the next edge.
- R10: Assume a car at a green light always leaves eventually. Under that assumption, a car waiting at a red light is served within a bounded number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_n | input | 1 | Car present at the north approach |
| sense_s | input | 1 | Car present at the south approach |
| sense_e | input | 1 | Car present at the east approach |
| go_n | output | 1 | North green |
| go_s | output | 1 | South green |
| go_e | output | 1 | East green |

## Verification
Two functions can fall in the same edge: one of the north/south pair releasing the hold flag, and the other setting it. A third case is both of them releasing it together. Directed vectors provoke the first case by dropping the south sensor in the very cycle that a latched north request turns green. They then raise an east request and require east to stay red until north ends. The second case is provoked by dropping both sensors at once while an east request waits; east must turn green exactly one edge later. A random run with cars that always leave a green light judges liveness by bounding how long any car waits at red.

// File: rtl/tlc_pkg.sv
package tlc_pkg;
   localparam int DIRS  = 3;
   localparam int IDX_N = 0;
   localparam int IDX_S = 1;
   localparam int IDX_E = 2;
   typedef logic [DIRS-1:0] dir_vec_t;
endpackage

// File: rtl/tlc_req_latch.sv
module tlc_req_latch
   import tlc_pkg::*;
#(
   parameter int W = DIRS
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] req_o
);
   initial begin
      if (W < 1) $error("tlc_req_latch: W must be positive");
   end

   for (genvar g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)            req_o[g] <= 1'b0;
         else if (clr_i[g])  req_o[g] <= 1'b0;
         else if (set_i[g])  req_o[g] <= 1'b1;
      end

      // R4
      clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
         clr_i[g] |=> !req_o[g]);
      // R2
      set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
         (set_i[g] && !clr_i[g]) |=> req_o[g]);
   end
endmodule

// File: rtl/tlc_ns_lane.sv
module tlc_ns_lane (
   input  logic clk,
   input  logic rst,
   input  logic req_n,
   input  logic req_s,
   input  logic req_e,
   input  logic sense_n,
   input  logic sense_s,
   output logic go_n,
   output logic go_s,
   output logic hold,
   output logic clr_n,
   output logic clr_s
);
   logic n_on, n_off, s_on, s_off;
   logic go_n_nx, go_s_nx, hold_nx;

   always_comb begin
      n_on  = req_n && !go_n && !req_e;
      s_on  = req_s && !go_s && !req_e;
      n_off = !n_on && go_n && !sense_n;
      s_off = !s_on && go_s && !sense_s;
      clr_n = n_off;
      clr_s = s_off;

      go_n_nx = go_n;
      if (n_on)       go_n_nx = 1'b1;
      else if (n_off) go_n_nx = 1'b0;
      go_s_nx = go_s;
      if (s_on)       go_s_nx = 1'b1;
      else if (s_off) go_s_nx = 1'b0;

      // north's hold decision, then south's overrides
      hold_nx = hold;
      if (n_on)                              hold_nx = 1'b1;
      else if (n_off && (!go_s || !sense_s)) hold_nx = 1'b0;
      if (s_on)                              hold_nx = 1'b1;
      else if (s_off && !(go_n || n_on))     hold_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         go_n <= 1'b0;
         go_s <= 1'b0;
         hold <= 1'b0;
      end else begin
         go_n <= go_n_nx;
         go_s <= go_s_nx;
         hold <= hold_nx;
      end
   end

   // R8
   hold_covers_chk: assert property (@(posedge clk) disable iff (rst)
      (go_n || go_s) |-> hold);
   // R5
   n_waits_east_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(go_n) |-> $past(!req_e));
   // R5
   s_waits_east_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(go_s) |-> $past(!req_e));
   // R4
   n_off_chk: assert property (@(posedge clk) disable iff (rst)
      (go_n && !sense_n) |=> !go_n);
endmodule

// File: rtl/tlc_east_lane.sv
module tlc_east_lane (
   input  logic clk,
   input  logic rst,
   input  logic req_e,
   input  logic hold,
   input  logic sense_e,
   output logic go_e,
   output logic clr_e
);
   logic e_on;

   always_comb begin
      e_on  = req_e && !hold && !go_e;
      clr_e = !e_on && go_e && !sense_e;
   end

   always_ff @(posedge clk) begin
      if (rst)        go_e <= 1'b0;
      else if (e_on)  go_e <= 1'b1;
      else if (clr_e) go_e <= 1'b0;
   end

   // R6
   e_needs_free_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(go_e) |-> $past(!hold));
   // R4
   e_off_chk: assert property (@(posedge clk) disable iff (rst)
      (go_e && !sense_e) |=> !go_e);
endmodule

// File: rtl/tlc_intersection.sv
module tlc_intersection
   import tlc_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic sense_n,
   input  logic sense_s,
   input  logic sense_e,
   output logic go_n,
   output logic go_s,
   output logic go_e
);
   dir_vec_t sense_v, clr_v, req_v;
   logic     hold;
   logic     clr_n, clr_s, clr_e;

   always_comb begin
      sense_v        = '0;
      sense_v[IDX_N] = sense_n;
      sense_v[IDX_S] = sense_s;
      sense_v[IDX_E] = sense_e;
      clr_v          = '0;
      clr_v[IDX_N]   = clr_n;
      clr_v[IDX_S]   = clr_s;
      clr_v[IDX_E]   = clr_e;
   end

   tlc_req_latch #(.W(DIRS)) u_req (
      .clk   (clk),
      .rst   (rst),
      .set_i (sense_v),
      .clr_i (clr_v),
      .req_o (req_v)
   );

   tlc_ns_lane u_ns (
      .clk     (clk),
      .rst     (rst),
      .req_n   (req_v[IDX_N]),
      .req_s   (req_v[IDX_S]),
      .req_e   (req_v[IDX_E]),
      .sense_n (sense_n),
      .sense_s (sense_s),
      .go_n    (go_n),
      .go_s    (go_s),
      .hold    (hold),
      .clr_n   (clr_n),
      .clr_s   (clr_s)
   );

   tlc_east_lane u_e (
      .clk     (clk),
      .rst     (rst),
      .req_e   (req_v[IDX_E]),
      .hold    (hold),
      .sense_e (sense_e),
      .go_e    (go_e),
      .clr_e   (clr_e)
   );

   // R7
   cross_green_chk: assert property (@(posedge clk) disable iff (rst)
      !(go_e && (go_n || go_s)));
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!go_n && !go_s && !go_e && !hold && (req_v == '0)));
endmodule

// File: tb/sim_tlc_intersection.sv
module sim_tlc_intersection;
   localparam int PERIOD = 10;
   localparam int NVEC   = 30;
   localparam int RCYC   = 4000;
   localparam int MAXW   = 64;
   // {sense e,s,n , expected go e,s,n after the edge}
   localparam logic [5:0] VEC [NVEC] = '{
      6'b001_000, 6'b001_001, 6'b000_000, 6'b000_000,
      6'b101_000, 6'b101_100, 6'b001_000, 6'b001_001,
      6'b101_001, 6'b100_000, 6'b100_100, 6'b000_000,
      6'b010_000, 6'b010_010, 6'b011_010, 6'b001_001,
      6'b101_001, 6'b101_001, 6'b100_000, 6'b100_100,
      6'b000_000, 6'b011_000, 6'b011_011, 6'b111_011,
      6'b100_000, 6'b100_100, 6'b000_000, 6'b010_000,
      6'b000_010, 6'b000_000
   };

   logic clk = 1'b0, rst = 1'b1;
   logic sense_n = 1'b0, sense_s = 1'b0, sense_e = 1'b0;
   logic go_n, go_s, go_e;
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   tlc_intersection u0 (.*);

   function automatic string tag_of(int k);
      if (k < 4)       return "R2/R3/R4";
      else if (k < 12) return "R5/R6";
      else if (k < 21) return "R8";
      else if (k < 27) return "R9";
      else             return "R2";
   endfunction

   task automatic check3(string tag, logic [2:0] got, logic [2:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: go(e,s,n) actual %b expected %b", tag, got, exp);
      end
   endtask

   initial begin
      #(PERIOD*200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [2:0] present;
      int         waitc [3];
      repeat (3) @(posedge clk);
      #(PERIOD/4);
      check3("R1", {go_e, go_s, go_n}, 3'b000);
      @(negedge clk) rst = 1'b0;

      for (int k = 0; k < NVEC; k++) begin
         @(negedge clk);
         {sense_e, sense_s, sense_n} = VEC[k][5:3];
         @(posedge clk);
         #(PERIOD/4);
         check3(tag_of(k), {go_e, go_s, go_n}, VEC[k][2:0]);
      end

      // R1: reset in the middle of traffic
      @(negedge clk) {sense_e, sense_s, sense_n} = 3'b011;
      repeat (3) @(negedge clk);
      check3("R1 pre", {go_e, go_s, go_n}, 3'b011);
      rst = 1'b1;
      @(posedge clk); #(PERIOD/4);
      check3("R1", {go_e, go_s, go_n}, 3'b000);
      @(negedge clk) begin rst = 1'b0; {sense_e, sense_s, sense_n} = 3'b000; end
      @(posedge clk); #(PERIOD/4);
      check3("R1 req", {go_e, go_s, go_n}, 3'b000);

      // R7 and R10: random cars that always leave a green eventually
      present = 3'b000;
      for (int i = 0; i < 3; i++) waitc[i] = 0;
      for (int c = 0; c < RCYC; c++) begin
         @(negedge clk);
         n_chk++;
         if (go_e && (go_n || go_s)) begin
            n_fail++;
            $display("FAIL R7: go(e,s,n) actual %b expected no cross green",
                     {go_e, go_s, go_n});
         end
         for (int i = 0; i < 3; i++) begin
            logic g;
            g = (i == 0) ? go_n : (i == 1) ? go_s : go_e;
            if (present[i] && !g) waitc[i]++;
            else                  waitc[i] = 0;
            if (waitc[i] > MAXW) begin
               n_fail++;
               $display("FAIL R10: lane %0d wait actual %0d expected <= %0d",
                        i, waitc[i], MAXW);
               waitc[i] = 0;
            end
            if (present[i] && g && ($urandom_range(1, 0) == 1)) present[i] = 1'b0;
            else if (!present[i] && ($urandom_range(3, 0) == 0)) present[i] = 1'b1;
         end
         {sense_e, sense_s, sense_n} = present;
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule